// File: doc/BRIEF.md
# Paged Data-Memory Access Router

This block steers each paged data-memory access issued by a processor core. A register-indirect instruction supplies only an 8-bit offset. The block holds a page register that supplies the upper byte, and the two together form a 16-bit effective address. When that address falls in the top 1 KB (0xFC00 to 0xFFFF), the access is served by a small on-chip RAM. Every other address goes out on the external address/data bus, with read and write strobes.

Software sets the page register in one of two ways. It can write the register directly, which is the way to reach the on-chip RAM. It can also write the port-2 output latch: that value is copied into the page register as well, so loading the latch with an address outside the on-chip window forces the access out to external memory. Each access lasts exactly two machine cycles and is run by a small state machine. The states are `ST_IDLE`, `ST_CYC1` (address phase) and `ST_CYC2` (data phase). Its transitions are:
- `start` from `ST_IDLE` or `ST_CYC2` into `ST_CYC1`;
- `advance` from `ST_CYC1` into `ST_CYC2`;
- `finish` from `ST_CYC2` into `ST_IDLE`;
- `abort` from any state into `ST_IDLE` on reset.

Reset is handled differently in the two cycles of a write. A reset sampled at the end of the first cycle drops the write. A reset sampled at the end of the second cycle still lets the write complete. Reset never clears the on-chip RAM. In debug mode, a write to the on-chip RAM is also shown on the external bus, without an external write strobe.

Top module: `paged_mem_router`

## Requirements
- R1: The effective address is {page, offset}: the page register forms bits 15:8 and `acc_offset` forms bits 7:0. For external accesses it appears on `ext_addr` during both access cycles.
- R2: An access is served on-chip exactly when the page captured at start is in 0xFC..0xFF. Any other page makes it an external access.
- R3: A `page_wr` pulse loads `page_wdata` into the page register. A `p2_wr` pulse loads `p2_wdata` into it as well. When both pulse in the same cycle, `p2_wdata` wins.
- R4: Reset sets the page register to 0x00. The first access after reset is therefore external, with `ext_addr[15:8]` equal to 0x00.
- R5: An `acc_start` accepted at a clock edge is followed by exactly two cycles, `ST_CYC1` and `ST_CYC2`. `ext_rd` and `ext_wr` are high only in `ST_CYC2` of an external access. Read data appears on `rd_data`, with `rd_valid` high, in the cycle after `ST_CYC2`.
- R6: An on-chip write commits at the end of `ST_CYC2`. A later on-chip read of the same address returns the written byte.
- R7: If reset is sampled at the end of `ST_CYC1` of an on-chip write, that RAM location keeps its previous value.
- R8: If reset is sampled at the end of `ST_CYC2` of an on-chip write, the new value is committed.
- R9: Reset leaves all on-chip RAM contents unchanged.
- R10: When `dbg_en` is high, an on-chip write drives its data on `ext_dout`, with `ext_dout_en` high and `ext_addr` set to the effective address, during `ST_CYC2`. `ext_wr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_wr | input | 1 | Direct write strobe for the page register |
| page_wdata | input | 8 | Data for a direct page write |
| p2_wr | input | 1 | Write strobe for the port-2 latch (shadowed into the page) |
| p2_wdata | input | 8 | Data for a port-2 latch write |
| acc_start | input | 1 | Starts a two-cycle paged access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_offset | input | 8 | Low address byte from the indirect register |
| acc_wdata | input | 8 | Write data |
| dbg_en | input | 1 | Debug mode: mirror on-chip writes onto the bus |
| ext_din | input | 8 | External read data, sampled at the end of `ST_CYC2` |
| ext_addr | output | 16 | External address bus |
| ext_dout | output | 8 | External write data |
| ext_dout_en | output | 1 | Data bus drive enable |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |

## Verification
The assertions take for granted that the core raises `acc_start` only in `ST_IDLE` or `ST_CYC2`. They also assume it holds `dbg_en` steady for the length of an access, and that reset lasts at least one full cycle. The stimulus issues each access through a single task that waits out both cycles before the next start. It changes `dbg_en` and the page only between accesses, and pulses reset for exactly one cycle at a chosen phase. Random page values are biased so that about half land in the on-chip window.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYC1 = 2'd1,
        ST_CYC2 = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic [15:0] addr;
        logic        wr;
        logic [7:0]  wdata;
        logic        onchip;
    } acc_req_t;
endpackage

// File: rtl/pmr_page_reg.sv
module pmr_page_reg #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          page_wr,
    input  logic [PW-1:0] page_wdata,
    input  logic          p2_wr,
    input  logic [PW-1:0] p2_wdata,
    output logic [PW-1:0] page_q
);
    // The port-2 shadow load takes priority over a direct write
    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (p2_wr)
            page_q <= p2_wdata;
        else if (page_wr)
            page_q <= page_wdata;
    end
endmodule

// File: rtl/pmr_seq.sv
module pmr_seq
    import pmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_start,
    output acc_state_e st,
    output logic       accept,
    output logic       in_cyc1,
    output logic       in_cyc2
);
    acc_state_e st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_IDLE;          // abort
        else
            st <= st_nx;
    end

    // Next state and state-decoded outputs
    always_comb begin
        st_nx   = st;
        accept  = 1'b0;
        in_cyc1 = 1'b0;
        in_cyc2 = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (acc_start) begin   // start
                    accept = 1'b1;
                    st_nx  = ST_CYC1;
                end
            end
            ST_CYC1: begin
                in_cyc1 = 1'b1;
                st_nx   = ST_CYC2;     // advance
            end
            ST_CYC2: begin
                in_cyc2 = 1'b1;
                if (acc_start) begin   // start (back to back)
                    accept = 1'b1;
                    st_nx  = ST_CYC1;
                end else begin
                    st_nx  = ST_IDLE;  // finish
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pmr_ram.sv
module pmr_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // No reset: contents survive reset
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/paged_mem_router.sv
module paged_mem_router
    import pmr_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        page_wr,
    input  logic [7:0]  page_wdata,
    input  logic        p2_wr,
    input  logic [7:0]  p2_wdata,
    input  logic        acc_start,
    input  logic        acc_write,
    input  logic [7:0]  acc_offset,
    input  logic [7:0]  acc_wdata,
    input  logic        dbg_en,
    input  logic [7:0]  ext_din,
    output logic [15:0] ext_addr,
    output logic [7:0]  ext_dout,
    output logic        ext_dout_en,
    output logic        ext_rd,
    output logic        ext_wr,
    output logic [7:0]  rd_data,
    output logic        rd_valid
);
    localparam int RAM_PAGES = 1 << (RAM_AW - 8);
    localparam int BASE_PAGE = 256 - RAM_PAGES;

    logic [7:0]    page_q;
    acc_state_e    st;
    logic          accept, in_cyc1, in_cyc2;
    acc_req_t      req_q;
    logic          ram_we;
    logic [7:0]    ram_rd;
    logic          busy, ext_sel, dbg_show;

    pmr_page_reg #(.PW(8)) u_page (
        .clk(clk), .rst(rst),
        .page_wr(page_wr), .page_wdata(page_wdata),
        .p2_wr(p2_wr), .p2_wdata(p2_wdata),
        .page_q(page_q)
    );

    pmr_seq u_seq (
        .clk(clk), .rst(rst), .acc_start(acc_start),
        .st(st), .accept(accept), .in_cyc1(in_cyc1), .in_cyc2(in_cyc2)
    );

    // Capture the request when it is accepted
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (accept) begin
            req_q.addr   <= {page_q, acc_offset};
            req_q.wr     <= acc_write;
            req_q.wdata  <= acc_wdata;
            req_q.onchip <= (32'(page_q) >= BASE_PAGE);
        end
    end

    // Write commit at the end of the data cycle, deliberately not reset-gated
    assign ram_we = in_cyc2 && req_q.wr && req_q.onchip;

    pmr_ram #(.AW(RAM_AW), .DW(8)) u_ram (
        .clk(clk), .we(ram_we),
        .waddr(req_q.addr[RAM_AW-1:0]), .wdata(req_q.wdata),
        .raddr(req_q.addr[RAM_AW-1:0]), .rdata(ram_rd)
    );

    assign busy     = in_cyc1 || in_cyc2;
    assign ext_sel  = busy && !req_q.onchip;
    assign dbg_show = busy && dbg_en && req_q.onchip && req_q.wr;

    always_comb begin
        ext_addr    = (ext_sel || dbg_show) ? req_q.addr : 16'h0000;
        ext_rd      = in_cyc2 && ext_sel && !req_q.wr;
        ext_wr      = in_cyc2 && ext_sel && req_q.wr;
        ext_dout_en = in_cyc2 && req_q.wr && (ext_sel || dbg_show);
        ext_dout    = ext_dout_en ? req_q.wdata : 8'h00;
    end

    // Registered read result
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= in_cyc2 && !req_q.wr;
            if (in_cyc2 && !req_q.wr)
                rd_data <= req_q.onchip ? ram_rd : ext_din;
        end
    end
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker
    import pmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_state_e st,
    input  logic [7:0] page_q,
    input  logic       p2_wr,
    input  logic [7:0] p2_wdata,
    input  logic       ext_rd,
    input  logic       ext_wr,
    input  logic       ext_dout_en,
    input  logic       rd_valid,
    input  logic       dbg_en,
    input  logic       ram_we,
    input  logic [15:0] req_addr
);
    a_r5_strobe_in_cyc2: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |-> (st == ST_CYC2));

    a_r2_strobe_outside_window: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |-> (req_addr[15:8] < 8'hFC));

    a_r5_two_cycles: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CYC1) |=> (st == ST_CYC2));

    a_r3_p2_shadow: assert property (@(posedge clk) disable iff (rst)
        p2_wr |=> (page_q == $past(p2_wdata)));

    a_r5_valid_after_cyc2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(st == ST_CYC2));

    a_r10_debug_mirror: assert property (@(posedge clk) disable iff (rst)
        (dbg_en && ram_we) |-> (ext_dout_en && !ext_wr));
endmodule

bind paged_mem_router pmr_checker u_chk (
    .clk(clk), .rst(rst), .st(st), .page_q(page_q),
    .p2_wr(p2_wr), .p2_wdata(p2_wdata),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_dout_en(ext_dout_en),
    .rd_valid(rd_valid), .dbg_en(dbg_en), .ram_we(ram_we),
    .req_addr(req_q.addr)
);

// File: tb/paged_mem_router_bench.sv
`timescale 1ns/1ps
module paged_mem_router_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        page_wr, p2_wr, acc_start, acc_write, dbg_en;
    logic [7:0]  page_wdata, p2_wdata, acc_offset, acc_wdata, ext_din;
    logic [15:0] ext_addr;
    logic [7:0]  ext_dout, rd_data;
    logic        ext_dout_en, ext_rd, ext_wr, rd_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] mdl_mem [1024];
    bit         mdl_vld [1024];
    logic [7:0] mdl_page;

    always #2 clk = ~clk;

    paged_mem_router u_paged_mem_router (
        .clk(clk), .rst(rst),
        .page_wr(page_wr), .page_wdata(page_wdata),
        .p2_wr(p2_wr), .p2_wdata(p2_wdata),
        .acc_start(acc_start), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .dbg_en(dbg_en), .ext_din(ext_din),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
        .ext_rd(ext_rd), .ext_wr(ext_wr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic bit is_onchip(input logic [7:0] pg);
        return pg >= 8'hFC;
    endfunction

    function automatic int ram_idx(input logic [7:0] pg, input logic [7:0] off);
        return int'({pg[1:0], off});
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_page(input int kind, input logic [7:0] v, input logic [7:0] v2);
        @(negedge clk);
        page_wr    = (kind != 1);
        page_wdata = v;
        p2_wr      = (kind != 0);
        p2_wdata   = (kind == 2) ? v2 : v;
        @(negedge clk);
        page_wr = 1'b0;
        p2_wr   = 1'b0;
        mdl_page = (kind == 0) ? v : p2_wdata;
    endtask

    // rst_at: 0 none, 1 reset sampled at end of cycle 1, 2 at end of cycle 2
    task automatic do_acc(input bit wr, input logic [7:0] off, input logic [7:0] d,
                          input int rst_at);
        bit         onc;
        int         idx;
        logic [7:0] din;
        onc = is_onchip(mdl_page);
        idx = ram_idx(mdl_page, off);
        din = 8'($urandom);
        @(negedge clk);
        acc_start = 1'b1; acc_write = wr; acc_offset = off; acc_wdata = d;
        ext_din = din;
        @(negedge clk);                       // ST_CYC1
        acc_start = 1'b0;
        chk("R5", "no strobe in cycle 1", {ext_rd, ext_wr}, 2'b00);
        if (!onc)
            chk("R1", "address in cycle 1", ext_addr, {mdl_page, off});
        if (rst_at == 1) rst = 1'b1;
        @(negedge clk);                       // ST_CYC2 or aborted
        if (rst_at == 1) begin
            rst = 1'b0;
            mdl_page = 8'h00;
            chk("R7", "bus quiet after abort", {ext_rd, ext_wr, ext_dout_en}, 3'b000);
            return;
        end
        chk("R2", "ext read strobe", ext_rd, !onc && !wr);
        chk("R5", "ext write strobe", ext_wr, !onc && wr);
        if (!onc)
            chk("R1", "address in cycle 2", ext_addr, {mdl_page, off});
        if (wr && (!onc || dbg_en)) begin
            chk("R10", "dout enable", ext_dout_en, 1'b1);
            chk("R10", "dout data", ext_dout, d);
            if (onc) chk("R10", "mirror address", ext_addr, {mdl_page, off});
        end
        if (rst_at == 2) rst = 1'b1;
        @(negedge clk);                       // after ST_CYC2
        if (wr && onc) begin
            mdl_mem[idx] = d;
            mdl_vld[idx] = 1'b1;
        end
        if (rst_at == 2) begin
            rst = 1'b0;
            mdl_page = 8'h00;
            return;
        end
        if (!wr) begin
            chk("R5", "read valid", rd_valid, 1'b1);
            if (!onc)
                chk("R5", "ext read data", rd_data, din);
            else if (mdl_vld[idx])
                chk("R6", "on-chip read data", rd_data, mdl_mem[idx]);
        end else begin
            chk("R5", "no valid on write", rd_valid, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; page_wr = 0; p2_wr = 0; acc_start = 0; acc_write = 0;
        page_wdata = 0; p2_wdata = 0; acc_offset = 0; acc_wdata = 0;
        dbg_en = 0; ext_din = 0; mdl_page = 8'h00;
        for (int i = 0; i < 1024; i++) mdl_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "reset: no read valid", rd_valid, 1'b0);
        chk("R5", "reset: no strobes", {ext_rd, ext_wr, ext_dout_en}, 3'b000);

        // R4: page resets to zero, so the first access is external
        do_acc(1'b0, 8'h3C, 8'h00, 0);

        // R3/R6: direct page write selects on-chip RAM, write and read back
        set_page(0, 8'hFC, 8'h00);
        do_acc(1'b1, 8'h00, 8'hA5, 0);
        do_acc(1'b0, 8'h00, 8'h00, 0);
        set_page(0, 8'hFF, 8'h00);
        do_acc(1'b1, 8'hFF, 8'h5A, 0);
        do_acc(1'b0, 8'hFF, 8'h00, 0);

        // R2: window edge pages 0xFB (external) and 0xFC (on-chip)
        set_page(0, 8'hFB, 8'h00);
        do_acc(1'b1, 8'h10, 8'h77, 0);
        do_acc(1'b0, 8'h10, 8'h00, 0);

        // R3: port-2 write shadows into page and forces external
        set_page(1, 8'h12, 8'h00);
        do_acc(1'b0, 8'h00, 8'h00, 0);
        // R3: both in the same cycle, port-2 value wins
        set_page(2, 8'hFD, 8'h40);
        do_acc(1'b1, 8'h44, 8'h99, 0);

        // R7: reset at end of cycle 1 keeps old value
        set_page(0, 8'hFE, 8'h00);
        do_acc(1'b1, 8'h20, 8'h11, 0);
        do_acc(1'b1, 8'h20, 8'h22, 1);
        set_page(0, 8'hFE, 8'h00);
        do_acc(1'b0, 8'h20, 8'h00, 0);
        chk("R7", "old value kept", rd_data, 8'h11);

        // R8/R9: reset at end of cycle 2 commits; reset leaves RAM intact
        do_acc(1'b1, 8'h21, 8'h33, 0);
        do_acc(1'b1, 8'h20, 8'h44, 2);
        set_page(0, 8'hFE, 8'h00);
        do_acc(1'b0, 8'h20, 8'h00, 0);
        chk("R8", "new value committed", rd_data, 8'h44);
        do_acc(1'b0, 8'h21, 8'h00, 0);
        chk("R9", "untouched by reset", rd_data, 8'h33);

        // R10: debug mirror of an on-chip write
        dbg_en = 1'b1;
        do_acc(1'b1, 8'h55, 8'hC3, 0);
        dbg_en = 1'b0;
        do_acc(1'b0, 8'h55, 8'h00, 0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [7:0] pv;
            sel = int'($urandom_range(0, 9));
            pv  = ($urandom_range(0, 1) == 1) ? 8'(8'hFC + $urandom_range(0, 3))
                                              : 8'($urandom);
            if (sel < 2)
                set_page(sel, pv, 8'h00);
            else if (sel == 2)
                set_page(2, 8'($urandom), pv);
            else begin
                dbg_en = ($urandom_range(0, 3) == 0);
                do_acc(($urandom_range(0, 1) == 1), 8'($urandom), 8'($urandom), 0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule